// File: doc/BRIEF.md
# Four-Channel Auxiliary DAC Controller with Ramp Generator

This block holds the output codes for four auxiliary DAC channels and updates them from one shared 16-bit control word. Each write carries a channel select, so a write changes exactly one channel. Updating all four channels takes four writes, and two channels can never change on the same write.

The ramp-capable channel (select code 0) can leave its static level and replay a 64-entry, 10-bit profile table. The table walks upward or downward at a step rate set by a prescaler, and the result is a smooth power-up or power-down envelope. After reset the table holds a raised-cosine shape. The host may rewrite it whenever no ramp is running. A ramp runs only in transmit mode. If the mode leaves transmit during a ramp, the block raises an error flag and freezes the ramp until transmit mode returns.

A powersave input freezes the output codes. While powersave is high, the output-enable of each disabled channel drops so that its pin can float.

Top module: `auxDacRamp`

## Requirements
- R1: A control write (`regWrEn` high) decodes `regWrData` as follows: bits 15:14 are the channel select (0..3), bit 13 is the enable, bit 12 is the ramp-mode request and bits 9:0 are the level. The write changes only the selected channel, and its effect shows on `dacCode` two rising edges after the write edge. A write whose bits 11:10 are not both zero is discarded.
- R2: Outside powersave, every `dacOutEn` bit is 1. An enabled channel outputs its level and a disabled channel outputs code 0. Channel c occupies `dacCode[c*10 +: 10]`.
- R3: While `powerSave` is high, the `dacCode` value is held, and writes made during powersave do not reach it. Each `dacOutEn` bit equals that channel's enable bit. When powersave ends, the codes resume one edge later.
- R4: Bit 12 selects ramp mode only when the channel select is 0; on the other channels it is ignored. In ramp mode, an enabled channel 0 outputs the table entry at the current ramp index instead of its level. The index is 0 after reset.
- R5: After reset, table entry i equals 512·(1 − cos(π·i/63)) rounded to the nearest integer and clamped to 1023.
- R6: A ramp-up visits indices 0..63 in order, and a ramp-down (`rampDown` high at start) visits indices 63..0. Each index is held for `rampRate`+1 transmit-mode cycles.
- R7: `rampBusy` rises on the edge that accepts a start. It stays high for 64·(`rampRate`+1) transmit-mode cycles and falls once the final entry has been held.
- R8: A start (`rampStart` high) is accepted only when `opMode` is 2'b10 (transmit), channel 0 is in ramp mode and no ramp is busy. The other encodings are 2'b00 for idle and 2'b01 for receive.
- R9: If `opMode` is not transmit on an edge while busy, `rampErr` is set and the index and prescaler stand still. The ramp resumes when transmit returns, and `rampErr` is cleared only by the next accepted start.
- R10: A table write (`tblWrEn`, `tblWrAddr`, `tblWrData`) while `rampBusy` is high is ignored. At any other time it replaces the addressed entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Control word write strobe |
| regWrData | input | 16 | Control word |
| tblWrEn | input | 1 | Profile table write strobe |
| tblWrAddr | input | 6 | Profile table entry index |
| tblWrData | input | 10 | Profile table entry value |
| opMode | input | 2 | Operating mode: 00 idle, 01 receive, 10 transmit |
| powerSave | input | 1 | Powersave request |
| rampStart | input | 1 | Ramp start command |
| rampDown | input | 1 | Ramp direction at start: 1 = downward |
| rampRate | input | 8 | Prescaler limit; each step lasts rampRate+1 cycles |
| dacCode | output | 40 | Four 10-bit output codes, channel c at bits c*10+9..c*10 |
| dacOutEn | output | 4 | Per-channel output drive enable |
| rampBusy | output | 1 | Ramp in progress |
| rampErr | output | 1 | Transmit mode was left during a ramp |

## Verification
A control write shows on `dacCode` two edges after the write edge: one edge loads the channel register and one edge loads the output code. The bench therefore samples on the falling edge after that second rising edge. During a ramp, the index loaded or stepped on edge s+m appears on the code at edge s+m+1. The bench computes the expected index from the number of transmit-mode edges counted so far, divided by `rampRate`+1, and compares every cycle of every ramp against that formula and the table model. It checks `rampBusy` every cycle against the 64·(`rampRate`+1) window, extended by the stalled cycles. The end of powersave is checked exactly one edge after release.

// File: rtl/auxDacPkg.sv
package auxDacPkg;

  localparam int DAC_W    = 10;
  localparam int CH_NUM   = 4;
  localparam int CTRL_W   = 16;
  // control word field positions
  localparam int SEL_LO   = 14;
  localparam int EN_BIT   = 13;
  localparam int RAMP_BIT = 12;
  localparam int RSV_HI   = 11;
  localparam int RSV_LO   = 10;

  typedef enum logic [1:0] {
    MODE_IDLE = 2'b00,
    MODE_RX   = 2'b01,
    MODE_TX   = 2'b10
  } opMode_e;

  // strobes from ramp control to datapath
  typedef struct packed {
    logic idxLoad;
    logic loadTop;
    logic idxStep;
  } rampStrobe_t;

  function automatic logic [DAC_W-1:0] cosProfile(input int idx, input int depth);
    real phase;
    real amp;
    int  val;
    amp   = real'(1 << (DAC_W - 1));
    phase = 3.141592653589793 * real'(idx) / real'(depth - 1);
    val   = $rtoi(amp * (1.0 - $cos(phase)) + 0.5);
    if (val > (1 << DAC_W) - 1) val = (1 << DAC_W) - 1;
    return val[DAC_W-1:0];
  endfunction

endpackage

// File: rtl/auxDacRampCtrl.sv
module auxDacRampCtrl
  import auxDacPkg::*;
#(
  parameter int TBL_AW = 6,
  parameter int RATE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rampStart,
  input  logic              rampDown,
  input  logic              rampEnable,
  input  logic              txMode,
  input  logic [RATE_W-1:0] rampRate,
  output rampStrobe_t       strobe,
  output logic              rampBusy,
  output logic              rampErr
);

  logic [RATE_W-1:0] preCnt;
  logic [TBL_AW-1:0] stepsLeft;
  logic              busyQ;
  logic              errQ;
  logic              startOk;
  logic              expire;
  logic              lastStep;

  assign startOk  = rampStart && rampEnable && txMode && !busyQ;
  assign expire   = busyQ && txMode && (preCnt == rampRate);
  assign lastStep = (stepsLeft == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ     <= 1'b0;
      errQ      <= 1'b0;
      preCnt    <= '0;
      stepsLeft <= '0;
    end else if (startOk) begin
      busyQ     <= 1'b1;
      errQ      <= 1'b0;
      preCnt    <= '0;
      stepsLeft <= '1;
    end else if (busyQ) begin
      if (!txMode) begin
        errQ <= 1'b1;
      end else if (expire) begin
        preCnt <= '0;
        if (lastStep) busyQ <= 1'b0;
        else          stepsLeft <= stepsLeft - 1'b1;
      end else begin
        preCnt <= preCnt + 1'b1;
      end
    end
  end

  always_comb begin
    strobe.idxLoad = startOk;
    strobe.loadTop = rampDown;
    strobe.idxStep = expire && !lastStep;
  end

  assign rampBusy = busyQ;
  assign rampErr  = errQ;

endmodule

// File: rtl/auxDacDatapath.sv
module auxDacDatapath
  import auxDacPkg::*;
#(
  parameter int TBL_AW = 6
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     regWrEn,
  input  logic [CTRL_W-1:0]        regWrData,
  input  logic                     tblWrEn,
  input  logic [TBL_AW-1:0]        tblWrAddr,
  input  logic [DAC_W-1:0]         tblWrData,
  input  logic                     powerSave,
  input  rampStrobe_t              strobe,
  input  logic                     rampBusy,
  output logic [CH_NUM*DAC_W-1:0]  dacCode,
  output logic [CH_NUM-1:0]        dacOutEn,
  output logic                     rampMode
);

  localparam int TBL_DEPTH = 1 << TBL_AW;
  localparam int SEL_W     = $clog2(CH_NUM);

  logic [DAC_W-1:0]  levelQ [CH_NUM];
  logic [CH_NUM-1:0] enQ;
  logic [DAC_W-1:0]  codeQ  [CH_NUM];
  logic [DAC_W-1:0]  srcLvl [CH_NUM];
  logic [DAC_W-1:0]  tbl    [TBL_DEPTH];
  logic [TBL_AW-1:0] idxQ;
  logic              downQ;
  logic              rampModeQ;
  logic              wrOk;
  logic [SEL_W-1:0]  wrSel;

  assign wrOk  = regWrEn && (regWrData[RSV_HI:RSV_LO] == 2'b00);
  assign wrSel = regWrData[SEL_LO +: SEL_W];

  // profile table, reset to the raised-cosine shape
  for (genvar g = 0; g < TBL_DEPTH; g++) begin : gTbl
    localparam logic [DAC_W-1:0] INIT_VAL = cosProfile(g, TBL_DEPTH);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        tbl[g] <= INIT_VAL;
      else if (tblWrEn && !rampBusy && (tblWrAddr == TBL_AW'(g)))
        tbl[g] <= tblWrData;
    end
  end

  // ramp index
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idxQ  <= '0;
      downQ <= 1'b0;
    end else if (strobe.idxLoad) begin
      idxQ  <= strobe.loadTop ? TBL_AW'(TBL_DEPTH - 1) : '0;
      downQ <= strobe.loadTop;
    end else if (strobe.idxStep) begin
      idxQ  <= downQ ? idxQ - 1'b1 : idxQ + 1'b1;
    end
  end

  // ramp-mode bit lives with channel 0 only
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          rampModeQ <= 1'b0;
    else if (wrOk && (wrSel == '0))     rampModeQ <= regWrData[RAMP_BIT];
  end
  assign rampMode = rampModeQ;

  for (genvar c = 0; c < CH_NUM; c++) begin : gCh
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        levelQ[c] <= '0;
        enQ[c]    <= 1'b0;
      end else if (wrOk && (wrSel == SEL_W'(c))) begin
        levelQ[c] <= regWrData[DAC_W-1:0];
        enQ[c]    <= regWrData[EN_BIT];
      end
    end

    if (c == 0) begin : gRampSrc
      assign srcLvl[c] = rampModeQ ? tbl[idxQ] : levelQ[c];
    end else begin : gLvlSrc
      assign srcLvl[c] = levelQ[c];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)           codeQ[c] <= '0;
      else if (!powerSave) codeQ[c] <= enQ[c] ? srcLvl[c] : '0;
    end

    assign dacCode[c*DAC_W +: DAC_W] = codeQ[c];
  end

  assign dacOutEn = powerSave ? enQ : '1;

endmodule

// File: rtl/auxDacRamp.sv
module auxDacRamp
  import auxDacPkg::*;
#(
  parameter int TBL_AW = 6,
  parameter int RATE_W = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    regWrEn,
  input  logic [15:0]             regWrData,
  input  logic                    tblWrEn,
  input  logic [TBL_AW-1:0]       tblWrAddr,
  input  logic [9:0]              tblWrData,
  input  logic [1:0]              opMode,
  input  logic                    powerSave,
  input  logic                    rampStart,
  input  logic                    rampDown,
  input  logic [RATE_W-1:0]       rampRate,
  output logic [39:0]             dacCode,
  output logic [3:0]              dacOutEn,
  output logic                    rampBusy,
  output logic                    rampErr
);

  rampStrobe_t strobe;
  logic        rampMode;
  logic        txMode;

  assign txMode = (opMode == MODE_TX);

  auxDacRampCtrl #(.TBL_AW(TBL_AW), .RATE_W(RATE_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .rampStart  (rampStart),
    .rampDown   (rampDown),
    .rampEnable (rampMode),
    .txMode     (txMode),
    .rampRate   (rampRate),
    .strobe     (strobe),
    .rampBusy   (rampBusy),
    .rampErr    (rampErr)
  );

  auxDacDatapath #(.TBL_AW(TBL_AW)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regWrData (regWrData),
    .tblWrEn   (tblWrEn),
    .tblWrAddr (tblWrAddr),
    .tblWrData (tblWrData),
    .powerSave (powerSave),
    .strobe    (strobe),
    .rampBusy  (rampBusy),
    .dacCode   (dacCode),
    .dacOutEn  (dacOutEn),
    .rampMode  (rampMode)
  );

endmodule

// File: rtl/auxDacRampChk.sv
module auxDacRampChk (
  input logic        clk,
  input logic        rstN,
  input logic [1:0]  opMode,
  input logic        powerSave,
  input logic        rampStart,
  input logic [39:0] dacCode,
  input logic        rampBusy,
  input logic        rampErr
);

  // R7
  busy_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rampBusy) |-> $past(rampStart));

  // R7
  busy_end_tx_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rampBusy) |-> $past(opMode == 2'b10));

  // R8
  start_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rampStart && (opMode != 2'b10) && !rampBusy) |=> !rampBusy);

  // R9
  err_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rampBusy && (opMode != 2'b10)) |=> rampErr);

  // R9
  err_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rampErr) |-> $past(rampBusy && (opMode != 2'b10)));

  // R3
  ps_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(powerSave) |-> $stable(dacCode));

endmodule

bind auxDacRamp auxDacRampChk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .opMode    (opMode),
  .powerSave (powerSave),
  .rampStart (rampStart),
  .dacCode   (dacCode),
  .rampBusy  (rampBusy),
  .rampErr   (rampErr)
);

// File: tb/auxDacRamp_tb.sv
`timescale 1ns/1ps
module auxDacRamp_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [15:0] regWrData = '0;
  logic        tblWrEn = 1'b0;
  logic [5:0]  tblWrAddr = '0;
  logic [9:0]  tblWrData = '0;
  logic [1:0]  opMode = 2'b10;
  logic        powerSave = 1'b0;
  logic        rampStart = 1'b0;
  logic        rampDown = 1'b0;
  logic [7:0]  rampRate = '0;
  logic [39:0] dacCode;
  logic [3:0]  dacOutEn;
  logic        rampBusy;
  logic        rampErr;

  int nChk = 0;
  int nErr = 0;
  bit done = 0;

  int mTbl [64];
  int mLvl [4];
  bit mEn  [4];
  bit mRamp = 0;
  int mIdx = 0;

  always #2.5 clk = ~clk;

  auxDacRamp u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .tblWrEn(tblWrEn), .tblWrAddr(tblWrAddr), .tblWrData(tblWrData),
    .opMode(opMode), .powerSave(powerSave), .rampStart(rampStart),
    .rampDown(rampDown), .rampRate(rampRate), .dacCode(dacCode),
    .dacOutEn(dacOutEn), .rampBusy(rampBusy), .rampErr(rampErr)
  );

  function automatic int codeOf(int c);
    return int'(dacCode[c*10 +: 10]);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    nChk++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expCode(int c);
    if (!mEn[c]) return 0;
    if (c == 0 && mRamp) return mTbl[mIdx];
    return mLvl[c];
  endfunction

  task automatic chkAll(string req);
    for (int c = 0; c < 4; c++) chk(codeOf(c) == expCode(c), req, codeOf(c), expCode(c));
    chk(dacOutEn == 4'b1111, req, int'(dacOutEn), 15);
  endtask

  // write, then wait until the code is due (two edges after the write edge)
  task automatic cfgWrite(int ch, bit en, bit ramp, int lvl, bit rsv = 0);
    @(negedge clk);
    regWrEn   = 1'b1;
    regWrData = {ch[1:0], en, ramp, rsv, 1'b0, lvl[9:0]};
    @(negedge clk);
    regWrEn = 1'b0;
    @(negedge clk);
    if (!rsv) begin
      mLvl[ch] = lvl;
      mEn[ch]  = en;
      if (ch == 0) mRamp = ramp;
    end
  endtask

  task automatic tblWrite(int addr, int val);
    @(negedge clk);
    tblWrEn = 1'b1; tblWrAddr = addr[5:0]; tblWrData = val[9:0];
    @(negedge clk);
    tblWrEn = 1'b0;
    if (!rampBusy) mTbl[addr] = val;
  endtask

  // R6 R7 R9 R10: cycle-by-cycle ramp comparison
  task automatic runRamp(bit down, int rate, int pauseAt, int pauseLen, int pokeAt);
    int total;
    int act;
    int idxPrev;
    int idxNow;
    total = 64 * (rate + 1) + pauseLen;
    @(negedge clk);
    rampRate = rate[7:0]; rampDown = down; rampStart = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rampStart = 1'b0;
    idxPrev = 0;
    for (int m = 0; m <= total + 3; m++) begin
      if (m > 0) @(negedge clk);
      if (pauseLen > 0 && m == pauseAt) opMode = 2'b01;
      if (pauseLen > 0 && m == pauseAt + pauseLen) opMode = 2'b10;
      if (m == pokeAt) begin tblWrEn = 1'b1; tblWrAddr = 6'd40; tblWrData = 10'd999; end
      if (m == pokeAt + 1) tblWrEn = 1'b0;
      act = m;
      if (pauseLen > 0 && m > pauseAt)
        act = m - ((m - pauseAt) < pauseLen ? (m - pauseAt) : pauseLen);
      idxNow = act / (rate + 1);
      if (idxNow > 63) idxNow = 63;
      if (down) idxNow = 63 - idxNow;
      chk(rampBusy == (act < 64 * (rate + 1)), "R7 busy window", int'(rampBusy), int'(act < 64 * (rate + 1)));
      chk(rampErr == (pauseLen > 0 && m > pauseAt), "R9 error flag", int'(rampErr), int'(pauseLen > 0 && m > pauseAt));
      if (m >= 1)
        chk(codeOf(0) == mTbl[idxPrev], "R6 ramp code", codeOf(0), mTbl[idxPrev]);
      idxPrev = idxNow;
    end
    mIdx = down ? 0 : 63;
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin
      int v;
      v = $rtoi(512.0 * (1.0 - $cos(3.141592653589793 * i / 63.0)) + 0.5);
      mTbl[i] = (v > 1023) ? 1023 : v;
    end
    for (int c = 0; c < 4; c++) begin mLvl[c] = 0; mEn[c] = 0; end

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // reset state, R2
    chkAll("R2 reset codes");
    chk(rampBusy == 0 && rampErr == 0, "R7 reset flags", int'({rampBusy, rampErr}), 0);

    // R1 R2: sweep of channels, levels and enables
    for (int ch = 0; ch < 4; ch++) begin
      int lv [6] = '{0, 1, 341, 512, 1022, 1023};
      for (int k = 0; k < 6; k++) begin
        cfgWrite(ch, (k % 3) != 2, 0, lv[k]);
        chkAll("R1 single-channel write");
      end
    end
    // R1: reserved bits nonzero -> discarded
    cfgWrite(1, 1, 0, 77, 1);
    chkAll("R1 reserved-bit write discarded");

    // R4: ramp bit on another channel is ignored
    cfgWrite(0, 1, 0, 600);
    cfgWrite(2, 1, 1, 123);
    chkAll("R4 ramp bit ignored off channel 0");

    // R8: start refused with channel 0 not in ramp mode
    @(negedge clk); rampStart = 1'b1;
    @(negedge clk); rampStart = 1'b0;
    chk(rampBusy == 0, "R8 start without ramp mode", int'(rampBusy), 0);

    // R4 R5: ramp mode shows entry at index 0
    cfgWrite(0, 1, 1, 600);
    chkAll("R4 ramp-mode static code");

    // R8: start refused in receive and idle mode
    opMode = 2'b01;
    @(negedge clk); rampStart = 1'b1;
    @(negedge clk); rampStart = 1'b0;
    chk(rampBusy == 0, "R8 start in receive", int'(rampBusy), 0);
    opMode = 2'b00;
    @(negedge clk); rampStart = 1'b1;
    @(negedge clk); rampStart = 1'b0;
    chk(rampBusy == 0, "R8 start in idle", int'(rampBusy), 0);
    opMode = 2'b10;

    // R5 R6 R7: full default table, upward and downward
    runRamp(0, 0, 0, 0, -1);
    runRamp(1, 2, 0, 0, -1);
    // R9: stall mid-ramp; R10: table write during busy ignored
    runRamp(0, 1, 20, 9, 4);
    runRamp(1, 0, 0, 0, -1);
    @(negedge clk);
    chkAll("R6 ramp-down rests at index 0");

    // R10: table rewrite while idle takes effect
    for (int i = 0; i < 64; i++) tblWrite(i, (i * 37 + 5) % 1024);
    runRamp(0, 0, 0, 0, -1);
    runRamp(0, 3, 0, 0, 10);

    // R3: powersave hold and output enables
    cfgWrite(0, 0, 0, 0);
    cfgWrite(1, 1, 0, 300);
    cfgWrite(2, 0, 0, 0);
    cfgWrite(3, 1, 0, 700);
    @(negedge clk); powerSave = 1'b1;
    @(negedge clk);
    chk(dacOutEn == 4'b1010, "R3 enables in powersave", int'(dacOutEn), 10);
    @(negedge clk); regWrEn = 1'b1; regWrData = {2'd1, 1'b1, 1'b0, 2'b00, 10'd500};
    @(negedge clk); regWrEn = 1'b0;
    @(negedge clk); regWrEn = 1'b1; regWrData = {2'd2, 1'b1, 1'b0, 2'b00, 10'd222};
    @(negedge clk); regWrEn = 1'b0;
    repeat (3) @(negedge clk);
    chk(codeOf(1) == 300, "R3 code held in powersave", codeOf(1), 300);
    chk(codeOf(2) == 0, "R3 code held in powersave", codeOf(2), 0);
    chk(dacOutEn == 4'b1110, "R3 enables follow writes", int'(dacOutEn), 14);
    powerSave = 1'b0;
    @(negedge clk);
    chk(codeOf(1) == 500, "R3 resume one edge after release", codeOf(1), 500);
    chk(codeOf(2) == 222, "R3 resume one edge after release", codeOf(2), 222);
    chk(dacOutEn == 4'b1111, "R2 enables outside powersave", int'(dacOutEn), 15);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChk++;
      nErr++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
      $finish;
    end
  end

endmodule